// File: doc/BRIEF.md
# PLL Divider Parameter Search Engine

This block walks through every legal pair of reference pre-divider N and feedback multiplier M for a PLL, given the input clock frequency, a requested window for the oscillator (DCO) frequency and a set of hardware limits. For each pair it offers a candidate on a valid/ready handshake. The candidate carries N, M, the internal reference frequency (input clock divided by N) and the DCO frequency, which is twice M times that reference. A downstream selector looks at each candidate. It either takes it, which ends the search, or lets it pass, and the engine then moves on to the next one.

Both loop bounds are worked out at run time with floor and ceiling divisions. All of these divisions run on one shared sequential restoring divider, so the block has no combinational dividers. A search begins with a start pulse while the engine is idle, and every operand is captured at that moment. When the search ends, the engine raises a done flag and holds it. A found flag next to it tells whether a candidate was taken.

Top module: `pll_div_search`

## Requirements
- R1: After reset, busy, done, found and candidate valid are all low. A start pulse while idle captures every input, clears done and found, and raises busy in the following cycle. A start pulse while busy is ignored, and input changes after the start have no effect on the search.
- R2: The first N tried is the larger of 1 and ceil(input clock / maximum reference).
- R3: The last N tried is the smaller of floor(input clock / minimum reference) and the maximum N.
- R4: For each N, the reference frequency offered is floor(input clock / N).
- R5: For each N, the first M tried is the larger of 1 and ceil(ceil(DCO minimum / reference) / 2).
- R6: For each N, the last M tried is the smallest of floor(floor(requested DCO maximum / reference) / 2), floor(floor(hardware DCO maximum / reference) / 2) and the maximum M. A requested maximum of 0 means no limit.
- R7: The DCO frequency offered equals 2 × M × reference, on DW = FW+MW+1 bits.
- R8: Candidates are offered with N ascending in the outer loop and M ascending in the inner loop. A candidate stays on the outputs, unchanged, until a cycle in which valid and ready are both high.
- R9: A handshake with take high ends the search. Done and found are high in the next cycle, and no further candidate is offered.
- R10: If no candidate is taken, or an N or M range is empty (start above stop), the empty range offers nothing. The search ends with done high and found low.
- R11: A division by zero yields an all-ones quotient. As a result, a minimum reference of 0 leaves N bounded only by the maximum N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only when idle |
| clkin_i | input | FW | Input clock frequency |
| dco_min_i | input | FW | Requested DCO minimum |
| dco_max_i | input | FW | Requested DCO maximum, 0 means no limit |
| ref_min_i | input | FW | Minimum internal reference |
| ref_max_i | input | FW | Maximum internal reference |
| dco_hw_max_i | input | FW | Hardware DCO maximum |
| n_max_i | input | NW | Maximum N |
| m_max_i | input | MW | Maximum M |
| cand_valid_o | output | 1 | Candidate present |
| cand_ready_i | input | 1 | Selector consumes the candidate |
| cand_take_i | input | 1 | With ready, the candidate is taken and the search stops |
| cand_n_o | output | NW | Candidate N |
| cand_m_o | output | MW | Candidate M |
| cand_ref_o | output | FW | Candidate internal reference |
| cand_dco_o | output | DW | Candidate DCO frequency |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | Search finished, held until the next start |
| found_o | output | 1 | A candidate was taken |

## Verification
The assertions check the following on every cycle:
- an offered candidate stays stable under backpressure;
- N and M stay inside their hardware limits;
- the reference times N never exceeds the input clock;
- the DCO lies between the requested minimum and both maxima;
- every divider result satisfies quotient × divisor + remainder = dividend;
- a take is followed at once by done with found.

Some properties can only be shown by the bench's scenarios, which compare against a behavioural model:
- the exact enumeration order and the exact loop bounds;
- that empty ranges are skipped;
- that a zero requested maximum or a zero minimum reference is handled as described;
- that a start pulse during a search leaves it untouched.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,  // waiting for start
    ST_NLO,   // clkin / ref_max in flight
    ST_NHI,   // clkin / ref_min in flight
    ST_REF,   // clkin / n in flight
    ST_MLO,   // dco_min / ref in flight
    ST_MREQ,  // dco_max / ref in flight
    ST_MHW,   // dco_hw_max / ref in flight
    ST_EMIT   // candidate offered
  } st_e;
endpackage

// File: rtl/pll_seq_div.sv
module pll_seq_div #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         go_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] r_o,
  output logic         done_o
);
  localparam int CW = $clog2(W + 1);

  logic [W:0]    rem_q, rem_nx, trial;
  logic [W-1:0]  quo_q, quo_nx, den_q, num_q;
  logic [CW-1:0] cnt_q;
  logic          run_q, done_q;

  always_comb begin
    trial = {rem_q[W-1:0], quo_q[W-1]};
    if (trial >= {1'b0, den_q}) begin
      rem_nx = trial - {1'b0, den_q};
      quo_nx = {quo_q[W-2:0], 1'b1};
    end else begin
      rem_nx = trial;
      quo_nx = {quo_q[W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      quo_q  <= '0;
      den_q  <= '0;
      num_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go_i) begin
        num_q <= a_i;
        den_q <= b_i;
        rem_q <= '0;
        if (b_i == '0) begin
          // zero divisor saturates
          quo_q  <= '1;
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end else begin
          quo_q <= a_i;
          cnt_q <= CW'(W);
          run_q <= 1'b1;
        end
      end else if (run_q) begin
        rem_q <= rem_nx;
        quo_q <= quo_nx;
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign q_o    = quo_q;
  assign r_o    = rem_q[W-1:0];
  assign done_o = done_q;

  // R4
  div_identity_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && den_q != '0) |->
      (((2*W)'(q_o) * (2*W)'(den_q) + (2*W)'(r_o)) == (2*W)'(num_q)) && (r_o < den_q));

  // R11
  div_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && den_q == '0) |-> (q_o == '1));
endmodule

// File: rtl/pll_dco_calc.sv
module pll_dco_calc #(
  parameter int FW = 32,
  parameter int MW = 12,
  localparam int DW = FW + MW + 1
) (
  input  logic [MW-1:0] m_i,
  input  logic [FW-1:0] ref_i,
  output logic [DW-1:0] dco_o
);
  assign dco_o = DW'({m_i, 1'b0}) * DW'(ref_i);
endmodule

// File: rtl/pll_div_search.sv
module pll_div_search
  import pll_search_pkg::*;
#(
  parameter int FW = 32,
  parameter int NW = 8,
  parameter int MW = 12,
  localparam int DW = FW + MW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [FW-1:0] clkin_i,
  input  logic [FW-1:0] dco_min_i,
  input  logic [FW-1:0] dco_max_i,
  input  logic [FW-1:0] ref_min_i,
  input  logic [FW-1:0] ref_max_i,
  input  logic [FW-1:0] dco_hw_max_i,
  input  logic [NW-1:0] n_max_i,
  input  logic [MW-1:0] m_max_i,
  output logic          cand_valid_o,
  input  logic          cand_ready_i,
  input  logic          cand_take_i,
  output logic [NW-1:0] cand_n_o,
  output logic [MW-1:0] cand_m_o,
  output logic [FW-1:0] cand_ref_o,
  output logic [DW-1:0] cand_dco_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          found_o
);
  localparam logic [FW-1:0] ONE = FW'(1);

  st_e           st_q;
  logic [FW-1:0] clkin_q, dmin_q, dmax_q, rmin_q, hw_q;
  logic [NW-1:0] nmax_q, n_q, n_hi_q, n_hi_c;
  logic [MW-1:0] mmax_q, m_q, m_hi_q, m_hi_c;
  logic [FW-1:0] n_lo_q, fint_q, m_lo_q, t1_q;
  logic [FW-1:0] div_a_q, div_b_q, div_q, div_r;
  logic          div_go_q, div_done;
  logic          done_q, found_q;
  logic [FW-1:0] q_ceil, q_half_ceil, q_lo1, hc_lo1, t2, tmin;

  pll_seq_div #(.W(FW)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (div_go_q),
    .a_i    (div_a_q),
    .b_i    (div_b_q),
    .q_o    (div_q),
    .r_o    (div_r),
    .done_o (div_done)
  );

  pll_dco_calc #(.FW(FW), .MW(MW)) u_dco (
    .m_i   (m_q),
    .ref_i (fint_q),
    .dco_o (cand_dco_o)
  );

  always_comb begin
    q_ceil      = div_q + {{(FW-1){1'b0}}, |div_r};
    q_half_ceil = (q_ceil >> 1) + {{(FW-1){1'b0}}, q_ceil[0]};
    q_lo1       = (q_ceil == '0) ? ONE : q_ceil;
    hc_lo1      = (q_half_ceil == '0) ? ONE : q_half_ceil;
    n_hi_c      = (div_q < FW'(nmax_q)) ? div_q[NW-1:0] : nmax_q;
    t2          = div_q >> 1;
    tmin        = (t1_q < t2) ? t1_q : t2;
    m_hi_c      = (tmin < FW'(mmax_q)) ? tmin[MW-1:0] : mmax_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      clkin_q  <= '0;
      dmin_q   <= '0;
      dmax_q   <= '0;
      rmin_q   <= '0;
      hw_q     <= '0;
      nmax_q   <= '0;
      mmax_q   <= '0;
      n_lo_q   <= '0;
      n_hi_q   <= '0;
      n_q      <= '0;
      fint_q   <= '0;
      m_lo_q   <= '0;
      t1_q     <= '0;
      m_hi_q   <= '0;
      m_q      <= '0;
      div_go_q <= 1'b0;
      div_a_q  <= '0;
      div_b_q  <= '0;
      done_q   <= 1'b0;
      found_q  <= 1'b0;
    end else begin
      div_go_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          clkin_q  <= clkin_i;
          dmin_q   <= dco_min_i;
          dmax_q   <= (dco_max_i == '0) ? '1 : dco_max_i;
          rmin_q   <= ref_min_i;
          hw_q     <= dco_hw_max_i;
          nmax_q   <= n_max_i;
          mmax_q   <= m_max_i;
          done_q   <= 1'b0;
          found_q  <= 1'b0;
          div_a_q  <= clkin_i;
          div_b_q  <= ref_max_i;
          div_go_q <= 1'b1;
          st_q     <= ST_NLO;
        end
        ST_NLO: if (div_done) begin
          n_lo_q   <= q_lo1;
          div_a_q  <= clkin_q;
          div_b_q  <= rmin_q;
          div_go_q <= 1'b1;
          st_q     <= ST_NHI;
        end
        ST_NHI: if (div_done) begin
          n_hi_q <= n_hi_c;
          if (n_lo_q > FW'(n_hi_c)) begin
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end else begin
            n_q      <= n_lo_q[NW-1:0];
            div_a_q  <= clkin_q;
            div_b_q  <= FW'(n_lo_q[NW-1:0]);
            div_go_q <= 1'b1;
            st_q     <= ST_REF;
          end
        end
        ST_REF: if (div_done) begin
          fint_q   <= div_q;
          div_a_q  <= dmin_q;
          div_b_q  <= div_q;
          div_go_q <= 1'b1;
          st_q     <= ST_MLO;
        end
        ST_MLO: if (div_done) begin
          m_lo_q   <= hc_lo1;
          div_a_q  <= dmax_q;
          div_b_q  <= fint_q;
          div_go_q <= 1'b1;
          st_q     <= ST_MREQ;
        end
        ST_MREQ: if (div_done) begin
          t1_q     <= div_q >> 1;
          div_a_q  <= hw_q;
          div_b_q  <= fint_q;
          div_go_q <= 1'b1;
          st_q     <= ST_MHW;
        end
        ST_MHW: if (div_done) begin
          m_hi_q <= m_hi_c;
          if (m_lo_q <= FW'(m_hi_c)) begin
            m_q  <= m_lo_q[MW-1:0];
            st_q <= ST_EMIT;
          end else if (n_q == n_hi_q) begin
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end else begin
            n_q      <= n_q + NW'(1);
            div_a_q  <= clkin_q;
            div_b_q  <= FW'(n_q + NW'(1));
            div_go_q <= 1'b1;
            st_q     <= ST_REF;
          end
        end
        ST_EMIT: if (cand_ready_i) begin
          if (cand_take_i) begin
            done_q  <= 1'b1;
            found_q <= 1'b1;
            st_q    <= ST_IDLE;
          end else if (m_q != m_hi_q) begin
            m_q <= m_q + MW'(1);
          end else if (n_q == n_hi_q) begin
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end else begin
            n_q      <= n_q + NW'(1);
            div_a_q  <= clkin_q;
            div_b_q  <= FW'(n_q + NW'(1));
            div_go_q <= 1'b1;
            st_q     <= ST_REF;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cand_valid_o = (st_q == ST_EMIT);
  assign cand_n_o     = n_q;
  assign cand_m_o     = m_q;
  assign cand_ref_o   = fint_q;
  assign busy_o       = (st_q != ST_IDLE);
  assign done_o       = done_q;
  assign found_o      = found_q;

  // R1
  start_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (busy_o && !done_o && !found_o));

  // R8
  cand_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cand_valid_o && !cand_ready_i) |=>
      (cand_valid_o && $stable(cand_n_o) && $stable(cand_m_o) && $stable(cand_ref_o)));

  // R3
  n_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cand_valid_o |-> (cand_n_o != '0 && cand_n_o <= nmax_q));

  // R6
  m_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cand_valid_o |-> (cand_m_o != '0 && cand_m_o <= mmax_q));

  // R4
  ref_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cand_valid_o |-> ((FW+NW)'(cand_ref_o) * (FW+NW)'(cand_n_o) <= (FW+NW)'(clkin_q)));

  // R6
  dco_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cand_valid_o |-> (cand_dco_o <= DW'(hw_q) && cand_dco_o <= DW'(dmax_q)));

  // R5
  dco_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cand_valid_o |-> (cand_dco_o >= DW'(dmin_q)));

  // R9
  take_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cand_valid_o && cand_ready_i && cand_take_i) |=> (done_o && found_o && !cand_valid_o));

  // R10
  found_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_o |-> done_o);
endmodule

// File: tb/pll_div_search_tb.sv
`timescale 1ns/1ps
module pll_div_search_tb_top;
  localparam int FW = 32;
  localparam int NW = 8;
  localparam int MW = 12;
  localparam int DW = FW + MW + 1;
  localparam longint ALL1 = 64'hFFFF_FFFF;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [FW-1:0] clkin = '0, dmin = '0, dmax = '0, rmin = '0, rmax = '0, hwmax = '0;
  logic [NW-1:0] nmax = '0;
  logic [MW-1:0] mmax = '0;
  logic          ready = 1'b0, take = 1'b0;
  logic          valid, busy, done, found;
  logic [NW-1:0] cn;
  logic [MW-1:0] cm;
  logic [FW-1:0] cref;
  logic [DW-1:0] cdco;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  pll_div_search #(.FW(FW), .NW(NW), .MW(MW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .clkin_i(clkin), .dco_min_i(dmin), .dco_max_i(dmax),
    .ref_min_i(rmin), .ref_max_i(rmax), .dco_hw_max_i(hwmax),
    .n_max_i(nmax), .m_max_i(mmax),
    .cand_valid_o(valid), .cand_ready_i(ready), .cand_take_i(take),
    .cand_n_o(cn), .cand_m_o(cm), .cand_ref_o(cref), .cand_dco_o(cdco),
    .busy_o(busy), .done_o(done), .found_o(found)
  );

  typedef struct { longint n; longint m; longint f; longint d; } cand_t;
  cand_t exp_q[$];

  function automatic longint fdiv(longint a, longint b);
    return (b == 0) ? ALL1 : a / b;
  endfunction
  function automatic longint cdiv(longint a, longint b);
    return (b == 0) ? ALL1 : (a + b - 1) / b;
  endfunction
  function automatic longint lmax(longint a, longint b);
    return (a > b) ? a : b;
  endfunction
  function automatic longint lmin(longint a, longint b);
    return (a < b) ? a : b;
  endfunction

  task automatic check(input string req, input string what, input longint act, input longint expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic build(input longint ck, dn, dx, rn, rx, hw, nx, mx);
    longint nlo, nhi, dxe;
    exp_q.delete();
    dxe = (dx == 0) ? ALL1 : dx;
    nlo = lmax(1, cdiv(ck, rx));
    nhi = lmin(fdiv(ck, rn), nx);
    for (longint n = nlo; n <= nhi; n++) begin
      longint f, mlo, mhi;
      f   = fdiv(ck, n);
      mlo = lmax(1, (cdiv(dn, f) + 1) / 2);
      mhi = lmin(lmin(fdiv(dxe, f) / 2, fdiv(hw, f) / 2), mx);
      for (longint m = mlo; m <= mhi; m++) begin
        cand_t c;
        c.n = n; c.m = m; c.f = f; c.d = 2 * m * f;
        exp_q.push_back(c);
      end
    end
  endtask

  task automatic run(input string tag, input longint ck, dn, dx, rn, rx, hw, nx, mx,
                     input int take_idx, input bit bp, input bit disturb);
    int idx = 0;
    int cyc = 0;
    bit exp_found = 1'b0;
    build(ck, dn, dx, rn, rx, hw, nx, mx);
    @(negedge clk);
    clkin = FW'(ck); dmin = FW'(dn); dmax = FW'(dx); rmin = FW'(rn);
    rmax = FW'(rx); hwmax = FW'(hw); nmax = NW'(nx); mmax = MW'(mx);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R1: busy raised, done/found cleared
    check("R1", {tag, " busy after start"}, longint'(busy), 1);
    check("R1", {tag, " done cleared"}, longint'(done), 0);
    // R1: inputs changed after start must not matter
    clkin = 32'd7; dmin = 32'd1; dmax = 32'd3; rmin = 32'd1; rmax = 32'd1;
    hwmax = 32'd5; nmax = 8'd200; mmax = 12'd1;
    forever begin
      @(negedge clk);
      cyc++;
      if (done) break;
      if (cyc > 20000) begin
        errors++; checks++;
        $display("FAIL %s watchdog: actual=timeout expected=done", tag);
        break;
      end
      start = disturb && (cyc == 40);
      ready = bp ? ((cyc % 3) != 0) : 1'b1;
      take  = (idx == take_idx);
      if (valid) begin
        if (idx >= exp_q.size()) begin
          errors++; checks++;
          $display("FAIL R10 %s extra candidate: actual=%0d expected=%0d", tag, idx, exp_q.size());
        end else begin
          check("R8", {tag, " n"}, longint'(cn), exp_q[idx].n);
          check("R8", {tag, " m"}, longint'(cm), exp_q[idx].m);
          check("R4", {tag, " ref"}, longint'(cref), exp_q[idx].f);
          check("R7", {tag, " dco"}, longint'(cdco), exp_q[idx].d);
        end
        if (ready) begin
          if (take) exp_found = 1'b1;
          idx++;
        end
      end
    end
    start = 1'b0; ready = 1'b0; take = 1'b0;
    if (!exp_found && take_idx >= 0 && take_idx < exp_q.size()) exp_found = 1'b1;
    // R9 / R10: final flags and candidate count
    check("R9", {tag, " found"}, longint'(found), longint'(exp_found));
    check("R10", {tag, " done"}, longint'(done), 1);
    check("R10", {tag, " count"}, idx, exp_found ? take_idx + 1 : exp_q.size());
    check("R9", {tag, " valid low at end"}, longint'(valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "reset busy", longint'(busy), 0);
    check("R1", "reset done", longint'(done), 0);
    check("R1", "reset found", longint'(found), 0);
    check("R1", "reset valid", longint'(valid), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run("R9 R2 take", 20_000_000, 100_000_000, 120_000_000, 2_000_000, 5_000_000,
        140_000_000, 8, 100, 2, 1'b0, 1'b0);
    run("R10 R8 R1 R3 R5 full", 20_000_000, 100_000_000, 120_000_000, 2_000_000, 5_000_000,
        140_000_000, 8, 100, -1, 1'b1, 1'b1);
    run("R6 unlimited", 20_000_000, 100_000_000, 0, 2_000_000, 5_000_000,
        140_000_000, 8, 100, -1, 1'b0, 1'b0);
    run("R6 mcap", 20_000_000, 100_000_000, 0, 2_000_000, 5_000_000,
        140_000_000, 8, 11, -1, 1'b1, 1'b0);
    run("R10 R3 empty n", 20_000_000, 100_000_000, 120_000_000, 2_000_000, 5_000_000,
        140_000_000, 3, 100, -1, 1'b0, 1'b0);
    run("R11 zero refmin", 20_000_000, 100_000_000, 120_000_000, 0, 5_000_000,
        140_000_000, 6, 100, 4, 1'b0, 1'b0);
    run("R5 R10 sparse m", 20_000_000, 130_000_000, 131_000_000, 2_000_000, 5_000_000,
        140_000_000, 8, 100, -1, 1'b1, 1'b0);
    run("R2 R7 small", 27_000_000, 400_000_000, 0, 500_000, 27_000_000,
        500_000_000, 3, 2000, -1, 1'b0, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule